// File: doc/BRIEF.md
# Configurable-Aspect Block RAM

This block is a synchronous on-chip memory holding 9,216 bits, of which 8,192 are data bits when the ninth bit of each byte lane is not used. The word width is a build-time parameter. Widths that are multiples of nine give each 8-bit lane a spare bit that an outer layer may use for parity. The depth follows from the width. A second parameter chooses how the two ports share the array: one port only, one writer plus one reader, two full read/write ports, or a split into two private half-size single-port memories.

Each port has an address, write data, a write strobe, a read strobe that is independent of the write strobe, per-lane write masks, an input-side clock enable that gates the port's access to the array, and an output-side clock enable for the optional output register. Reads are synchronous. Data arrives one clock after the request, or two clocks after it when the output register is built in. A read that meets a write to the same word in the same cycle always returns the word as it was before that write.

Top module: `cfg_block_ram`

## Requirements
- R1: `WIDTH` must be one of 1, 2, 4, 8, 9, 16, 18, 32 or 36. Depth is 9216/`WIDTH` for widths divisible by nine and 8192/`WIDTH` otherwise, so every address from 0 to depth-1 stores a word. Any other width, or a two-read/write-port build wider than 18 bits, stops elaboration.
- R2: Reset clears both read outputs to zero. A read strobe sampled on a clock edge with the input enable high shows its word after that edge when `OUT_REG`=0. When `OUT_REG`=1 the word shows after the following edge, and after the first edge the output still shows its earlier value.
- R3: While no read is accepted on a port, that port's read data holds its last value, even when the address changes.
- R4: Write masks work per lane. A lane is 9 bits for widths 9, 18 and 36, 8 bits for widths 8, 16 and 32, and the whole word for widths below 8. Lane k is bits [k*lane+lane-1 : k*lane] and is enabled by mask bit k. A masked lane keeps its stored bits.
- R5: A read of a word that is written in the same cycle returns the old contents. This holds for the same port and for the other port.
- R6: With two read/write ports, when both ports write the same word in one cycle, port A's data is stored in each lane that A enables. A lane enabled only by B takes B's data.
- R7: With the input enable low, a port's write has no effect on the array and its read is not accepted.
- R8: With `OUT_REG`=1 and the output enable low, the port's read output holds. When the enable rises, the output loads the pending word on the next edge.
- R9: In single-port mode (`MODE`=`BRAM_SINGLE`), port B does nothing and its read data stays zero. In writer/reader mode (`MODE`=`BRAM_SIMPLE_DP`), port A only writes and port B only reads, both in the same cycle. A's read strobe and B's write strobe are ignored, and A's read data stays zero.
- R10: In split mode (`MODE`=`BRAM_SPLIT`), port A owns the lower half of the array and port B the upper half. The address MSB is ignored, so each port addresses depth/2 words of its own. The same address on A and B names two different words.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ports |
| rst | input | 1 | Synchronous active-high reset of read registers |
| a_addr | input | AW | Port A word address |
| a_wdata | input | WIDTH | Port A write data |
| a_be | input | NBE | Port A per-lane write mask |
| a_we | input | 1 | Port A write strobe |
| a_re | input | 1 | Port A read strobe |
| a_ce_in | input | 1 | Port A input/array clock enable |
| a_ce_out | input | 1 | Port A output register clock enable |
| a_rdata | output | WIDTH | Port A read data |
| b_addr | input | AW | Port B word address |
| b_wdata | input | WIDTH | Port B write data |
| b_be | input | NBE | Port B per-lane write mask |
| b_we | input | 1 | Port B write strobe |
| b_re | input | 1 | Port B read strobe |
| b_ce_in | input | 1 | Port B input/array clock enable |
| b_ce_out | input | 1 | Port B output register clock enable |
| b_rdata | output | WIDTH | Port B read data |

## Verification
The following are checked on every cycle by assertions:
- the read registers and output registers hold when nothing loads them;
- the output register follows its input by one edge;
- port A's lane wins on a double write;
- the idle port in writer/reader mode stays at zero;
- split-mode accesses stay inside each port's own half.

Only the directed scenarios can show the rest:
- end-to-end latency counted from the request;
- old-data return on collisions between ports and on a single port;
- lane masking at widths 18 and 36;
- the top addresses of each geometry;
- that two same-numbered addresses really are separate words in split mode.

// File: rtl/bram_cfg_pkg.sv
package bram_cfg_pkg;

    typedef enum logic [1:0] {
        BRAM_SINGLE    = 2'd0,
        BRAM_SIMPLE_DP = 2'd1,
        BRAM_TRUE_DP   = 2'd2,
        BRAM_SPLIT     = 2'd3
    } bram_mode_e;

    localparam int unsigned ARRAY_BITS     = 9216;
    localparam int unsigned DATA_ONLY_BITS = 8192;
    localparam int unsigned TWO_RW_MAX_W   = 18;

    // Per-port request after mode and enable qualification
    typedef struct packed {
        logic wr;
        logic rd;
    } bram_op_t;

    function automatic bit width_ok(input int w);
        case (w)
            1, 2, 4, 8, 9, 16, 18, 32, 36: return 1'b1;
            default:                      return 1'b0;
        endcase
    endfunction

    function automatic bit has_spare_bit(input int w);
        return (w % 9) == 0;
    endfunction

    function automatic int depth_of(input int w);
        if (!width_ok(w)) return 8192;
        return has_spare_bit(w) ? ARRAY_BITS / w : DATA_ONLY_BITS / w;
    endfunction

    function automatic int lane_of(input int w);
        if (!width_ok(w) || w < 8) return (w < 1) ? 1 : w;
        return has_spare_bit(w) ? 9 : 8;
    endfunction

endpackage

// File: rtl/bram_port_ctl.sv
module bram_port_ctl
    import bram_cfg_pkg::*;
#(
    parameter bram_mode_e MODE   = BRAM_TRUE_DP,
    parameter bit         IS_B   = 1'b0,
    parameter int         AW     = 9
) (
    input  logic          we_i,
    input  logic          re_i,
    input  logic          ce_i,
    input  logic [AW-1:0] addr_i,
    output bram_op_t      op_o,
    output logic [AW-1:0] addr_o
);
    localparam bit PORT_LIVE = !(MODE == BRAM_SINGLE && IS_B);
    localparam bit MAY_WRITE = PORT_LIVE && !(MODE == BRAM_SIMPLE_DP && IS_B);
    localparam bit MAY_READ  = PORT_LIVE && !(MODE == BRAM_SIMPLE_DP && !IS_B);

    always_comb begin
        op_o.wr = ce_i && we_i && MAY_WRITE;
        op_o.rd = ce_i && re_i && MAY_READ;
    end

    generate
        if (MODE == BRAM_SPLIT) begin : g_half
            assign addr_o = {IS_B, addr_i[AW-2:0]};
        end else begin : g_full
            assign addr_o = addr_i;
        end
    endgenerate

endmodule

// File: rtl/bram_core.sv
module bram_core
    import bram_cfg_pkg::*;
#(
    parameter bram_mode_e MODE  = BRAM_TRUE_DP,
    parameter int         WIDTH = 18,
    parameter int         DEPTH = 512,
    parameter int         LANE  = 9,
    localparam int        AW    = $clog2(DEPTH),
    localparam int        NBE   = WIDTH / LANE
) (
    input  logic             clk,
    input  logic             rst,
    input  bram_op_t         a_op,
    input  logic [AW-1:0]    a_addr,
    input  logic [WIDTH-1:0] a_wd,
    input  logic [NBE-1:0]   a_be,
    input  bram_op_t         b_op,
    input  logic [AW-1:0]    b_addr,
    input  logic [WIDTH-1:0] b_wd,
    input  logic [NBE-1:0]   b_be,
    output logic [WIDTH-1:0] a_rd,
    output logic [WIDTH-1:0] b_rd
);
    logic [WIDTH-1:0] mem [DEPTH];

    // B first, A last: A's lanes override on a shared word
    always_ff @(posedge clk) begin
        for (int l = 0; l < NBE; l++) begin
            if (b_op.wr && b_be[l]) mem[b_addr][l*LANE +: LANE] <= b_wd[l*LANE +: LANE];
        end
        for (int l = 0; l < NBE; l++) begin
            if (a_op.wr && a_be[l]) mem[a_addr][l*LANE +: LANE] <= a_wd[l*LANE +: LANE];
        end
    end

    // Nonblocking reads see the pre-write word
    always_ff @(posedge clk) begin
        if (rst) begin
            a_rd <= '0;
            b_rd <= '0;
        end else begin
            if (a_op.rd) a_rd <= mem[a_addr];
            if (b_op.rd) b_rd <= mem[b_addr];
        end
    end

    assert_a_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !a_op.rd |=> $stable(a_rd));
    assert_b_hold_R3: assert property (@(posedge clk) disable iff (rst)
        !b_op.rd |=> $stable(b_rd));
    assert_a_lane_wins_R6: assert property (@(posedge clk) disable iff (rst)
        (a_op.wr && b_op.wr && a_addr == b_addr && a_be[0])
        |=> mem[$past(a_addr)][LANE-1:0] == $past(a_wd[LANE-1:0]));
    assert_split_a_low_R10: assert property (@(posedge clk) disable iff (rst)
        (MODE == BRAM_SPLIT && (a_op.wr || a_op.rd)) |-> !a_addr[AW-1]);
    assert_split_b_high_R10: assert property (@(posedge clk) disable iff (rst)
        (MODE == BRAM_SPLIT && (b_op.wr || b_op.rd)) |-> b_addr[AW-1]);

endmodule

// File: rtl/bram_out_stage.sv
module bram_out_stage #(
    parameter int WIDTH   = 18,
    parameter bit OUT_REG = 1'b0
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ce,
    input  logic [WIDTH-1:0] din,
    output logic [WIDTH-1:0] dout
);
    generate
        if (OUT_REG) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst)     dout <= '0;
                else if (ce) dout <= din;
            end

            assert_out_hold_R8: assert property (@(posedge clk) disable iff (rst)
                !ce |=> $stable(dout));
            assert_out_follow_R2: assert property (@(posedge clk) disable iff (rst)
                ce |=> dout == $past(din));
        end else begin : g_wire
            assign dout = din;
        end
    endgenerate

endmodule

// File: rtl/cfg_block_ram.sv
module cfg_block_ram
    import bram_cfg_pkg::*;
#(
    parameter bram_mode_e MODE    = BRAM_TRUE_DP,
    parameter int         WIDTH   = 18,
    parameter bit         OUT_REG = 1'b1,
    localparam int        DEPTH   = depth_of(WIDTH),
    localparam int        AW      = $clog2(DEPTH),
    localparam int        LANE    = lane_of(WIDTH),
    localparam int        NBE     = WIDTH / LANE
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [AW-1:0]    a_addr,
    input  logic [WIDTH-1:0] a_wdata,
    input  logic [NBE-1:0]   a_be,
    input  logic             a_we,
    input  logic             a_re,
    input  logic             a_ce_in,
    input  logic             a_ce_out,
    output logic [WIDTH-1:0] a_rdata,
    input  logic [AW-1:0]    b_addr,
    input  logic [WIDTH-1:0] b_wdata,
    input  logic [NBE-1:0]   b_be,
    input  logic             b_we,
    input  logic             b_re,
    input  logic             b_ce_in,
    input  logic             b_ce_out,
    output logic [WIDTH-1:0] b_rdata
);
    generate
        if (!width_ok(WIDTH)) begin : g_bad_width
            $error("cfg_block_ram: WIDTH %0d is not a legal aspect ratio", WIDTH);
        end
        if (MODE == BRAM_TRUE_DP && WIDTH > TWO_RW_MAX_W) begin : g_bad_tdp
            $error("cfg_block_ram: two read/write ports need WIDTH <= %0d", TWO_RW_MAX_W);
        end
    endgenerate

    bram_op_t         a_op, b_op;
    logic [AW-1:0]    a_addr_q, b_addr_q;
    logic [WIDTH-1:0] a_core_rd, b_core_rd;

    bram_port_ctl #(.MODE(MODE), .IS_B(1'b0), .AW(AW)) u_ctl_a (
        .we_i(a_we), .re_i(a_re), .ce_i(a_ce_in), .addr_i(a_addr),
        .op_o(a_op), .addr_o(a_addr_q)
    );

    bram_port_ctl #(.MODE(MODE), .IS_B(1'b1), .AW(AW)) u_ctl_b (
        .we_i(b_we), .re_i(b_re), .ce_i(b_ce_in), .addr_i(b_addr),
        .op_o(b_op), .addr_o(b_addr_q)
    );

    bram_core #(.MODE(MODE), .WIDTH(WIDTH), .DEPTH(DEPTH), .LANE(LANE)) u_core (
        .clk(clk), .rst(rst),
        .a_op(a_op), .a_addr(a_addr_q), .a_wd(a_wdata), .a_be(a_be),
        .b_op(b_op), .b_addr(b_addr_q), .b_wd(b_wdata), .b_be(b_be),
        .a_rd(a_core_rd), .b_rd(b_core_rd)
    );

    bram_out_stage #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) u_out_a (
        .clk(clk), .rst(rst), .ce(a_ce_out), .din(a_core_rd), .dout(a_rdata)
    );

    bram_out_stage #(.WIDTH(WIDTH), .OUT_REG(OUT_REG)) u_out_b (
        .clk(clk), .rst(rst), .ce(b_ce_out), .din(b_core_rd), .dout(b_rdata)
    );

    assert_writer_port_quiet_R9: assert property (@(posedge clk) disable iff (rst)
        (MODE == BRAM_SIMPLE_DP || MODE == BRAM_SINGLE) |->
            ((MODE == BRAM_SIMPLE_DP) ? (a_rdata == '0) : (b_rdata == '0)));

endmodule

// File: tb/test_cfg_block_ram.sv
`timescale 1ns/1ps
module test_cfg_block_ram;
    import bram_cfg_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // ---- two read/write ports, 512x18, output register ----
    logic [8:0]  t_a_addr, t_b_addr;
    logic [17:0] t_a_wd, t_b_wd, t_a_rd, t_b_rd;
    logic [1:0]  t_a_be, t_b_be;
    logic t_a_we, t_a_re, t_a_ci, t_a_co, t_b_we, t_b_re, t_b_ci, t_b_co;

    cfg_block_ram #(.MODE(BRAM_TRUE_DP), .WIDTH(18), .OUT_REG(1'b1)) i_cfg_block_ram (
        .clk(clk), .rst(rst),
        .a_addr(t_a_addr), .a_wdata(t_a_wd), .a_be(t_a_be), .a_we(t_a_we), .a_re(t_a_re),
        .a_ce_in(t_a_ci), .a_ce_out(t_a_co), .a_rdata(t_a_rd),
        .b_addr(t_b_addr), .b_wdata(t_b_wd), .b_be(t_b_be), .b_we(t_b_we), .b_re(t_b_re),
        .b_ce_in(t_b_ci), .b_ce_out(t_b_co), .b_rdata(t_b_rd)
    );

    // ---- writer/reader, 256x36, no output register ----
    logic [7:0]  s_a_addr, s_b_addr;
    logic [35:0] s_a_wd, s_b_wd, s_a_rd, s_b_rd;
    logic [3:0]  s_a_be, s_b_be;
    logic s_a_we, s_a_re, s_b_we, s_b_re;

    cfg_block_ram #(.MODE(BRAM_SIMPLE_DP), .WIDTH(36), .OUT_REG(1'b0)) i_sdp (
        .clk(clk), .rst(rst),
        .a_addr(s_a_addr), .a_wdata(s_a_wd), .a_be(s_a_be), .a_we(s_a_we), .a_re(s_a_re),
        .a_ce_in(1'b1), .a_ce_out(1'b1), .a_rdata(s_a_rd),
        .b_addr(s_b_addr), .b_wdata(s_b_wd), .b_be(s_b_be), .b_we(s_b_we), .b_re(s_b_re),
        .b_ce_in(1'b1), .b_ce_out(1'b1), .b_rdata(s_b_rd)
    );

    // ---- split, 1024x9, no output register ----
    logic [9:0] p_a_addr, p_b_addr;
    logic [8:0] p_a_wd, p_b_wd, p_a_rd, p_b_rd;
    logic p_a_we, p_a_re, p_b_we, p_b_re;

    cfg_block_ram #(.MODE(BRAM_SPLIT), .WIDTH(9), .OUT_REG(1'b0)) i_split (
        .clk(clk), .rst(rst),
        .a_addr(p_a_addr), .a_wdata(p_a_wd), .a_be(1'b1), .a_we(p_a_we), .a_re(p_a_re),
        .a_ce_in(1'b1), .a_ce_out(1'b1), .a_rdata(p_a_rd),
        .b_addr(p_b_addr), .b_wdata(p_b_wd), .b_be(1'b1), .b_we(p_b_we), .b_re(p_b_re),
        .b_ce_in(1'b1), .b_ce_out(1'b1), .b_rdata(p_b_rd)
    );

    // ---- single port, 1024x8, no output register ----
    logic [9:0] o_a_addr, o_b_addr;
    logic [7:0] o_a_wd, o_b_wd, o_a_rd, o_b_rd;
    logic o_a_we, o_a_re, o_b_we, o_b_re;

    cfg_block_ram #(.MODE(BRAM_SINGLE), .WIDTH(8), .OUT_REG(1'b0)) i_single (
        .clk(clk), .rst(rst),
        .a_addr(o_a_addr), .a_wdata(o_a_wd), .a_be(1'b1), .a_we(o_a_we), .a_re(o_a_re),
        .a_ce_in(1'b1), .a_ce_out(1'b1), .a_rdata(o_a_rd),
        .b_addr(o_b_addr), .b_wdata(o_b_wd), .b_be(1'b1), .b_we(o_b_we), .b_re(o_b_re),
        .b_ce_in(1'b1), .b_ce_out(1'b1), .b_rdata(o_b_rd)
    );

    task automatic chk(input string req, input string what,
                       input logic [35:0] act, input logic [35:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic tick(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic idle_all();
        t_a_addr = '0; t_b_addr = '0; t_a_wd = '0; t_b_wd = '0; t_a_be = 2'b11; t_b_be = 2'b11;
        t_a_we = 0; t_a_re = 0; t_b_we = 0; t_b_re = 0;
        t_a_ci = 1; t_a_co = 1; t_b_ci = 1; t_b_co = 1;
        s_a_addr = '0; s_b_addr = '0; s_a_wd = '0; s_b_wd = '0; s_a_be = 4'hF; s_b_be = 4'hF;
        s_a_we = 0; s_a_re = 0; s_b_we = 0; s_b_re = 0;
        p_a_addr = '0; p_b_addr = '0; p_a_wd = '0; p_b_wd = '0;
        p_a_we = 0; p_a_re = 0; p_b_we = 0; p_b_re = 0;
        o_a_addr = '0; o_b_addr = '0; o_a_wd = '0; o_b_wd = '0;
        o_a_we = 0; o_a_re = 0; o_b_we = 0; o_b_re = 0;
    endtask

    task automatic t_wr_a(input logic [8:0] ad, input logic [17:0] d, input logic [1:0] be);
        t_a_addr = ad; t_a_wd = d; t_a_be = be; t_a_we = 1;
        tick(1);
        t_a_we = 0; t_a_be = 2'b11;
    endtask

    task automatic t_rd_b(input logic [8:0] ad, output logic [17:0] d);
        t_b_addr = ad; t_b_re = 1;
        tick(1);
        t_b_re = 0;
        tick(1);
        d = t_b_rd;
    endtask

    task automatic test_reset();
        chk("R2", "tdp a after reset", 36'(t_a_rd), 36'h0);
        chk("R2", "tdp b after reset", 36'(t_b_rd), 36'h0);
        chk("R2", "sdp b after reset", s_b_rd, 36'h0);
        chk("R2", "split a after reset", 36'(p_a_rd), 36'h0);
    endtask

    task automatic test_latency_depth();
        logic [17:0] d;
        t_wr_a(9'd5, 18'h2A5A5, 2'b11);
        t_b_addr = 9'd5; t_b_re = 1;
        tick(1);
        t_b_re = 0;
        chk("R2", "output register still old after first edge", 36'(t_b_rd), 36'h0);
        tick(1);
        chk("R2", "word after second edge", 36'(t_b_rd), 36'h2A5A5);
        t_wr_a(9'd511, 18'h1C3C3, 2'b11);
        t_rd_b(9'd511, d);
        chk("R1", "top address 511 of 512x18", 36'(d), 36'h1C3C3);
    endtask

    task automatic test_lanes_tdp();
        logic [17:0] d;
        t_wr_a(9'd7, 18'h3FFFF, 2'b11);
        t_wr_a(9'd7, 18'h00000, 2'b01);
        t_rd_b(9'd7, d);
        chk("R4", "lane0 cleared, lane1 kept", 36'(d), 36'h3FE00);
        t_wr_a(9'd7, 18'h00000, 2'b10);
        t_rd_b(9'd7, d);
        chk("R4", "lane1 cleared too", 36'(d), 36'h0);
    endtask

    task automatic test_hold();
        t_a_addr = 9'd5; t_a_re = 1;
        tick(1);
        t_a_re = 0;
        tick(1);
        chk("R2", "port a read", 36'(t_a_rd), 36'h2A5A5);
        t_a_addr = 9'd511;
        tick(3);
        chk("R3", "read data holds with read strobe low", 36'(t_a_rd), 36'h2A5A5);
    endtask

    task automatic test_collisions();
        logic [17:0] d;
        t_wr_a(9'd9, 18'h11111, 2'b11);
        t_a_addr = 9'd9; t_a_wd = 18'h22222; t_a_we = 1; t_a_re = 1;
        tick(1);
        t_a_we = 0; t_a_re = 0;
        tick(1);
        chk("R5", "same-port read during write is old", 36'(t_a_rd), 36'h11111);
        t_rd_b(9'd9, d);
        chk("R5", "write landed", 36'(d), 36'h22222);
        t_a_addr = 9'd9; t_a_wd = 18'h33333; t_a_we = 1;
        t_b_addr = 9'd9; t_b_re = 1;
        tick(1);
        t_a_we = 0; t_b_re = 0;
        tick(1);
        chk("R5", "cross-port read during write is old", 36'(t_b_rd), 36'h22222);
        t_a_addr = 9'd12; t_a_wd = 18'h00001; t_a_be = 2'b01; t_a_we = 1;
        t_b_addr = 9'd12; t_b_wd = 18'h3FFFF; t_b_be = 2'b11; t_b_we = 1;
        tick(1);
        t_a_we = 0; t_b_we = 0; t_a_be = 2'b11;
        t_rd_b(9'd12, d);
        chk("R6", "A wins lane0, B fills lane1", 36'(d), 36'h3FE01);
    endtask

    task automatic test_enables();
        logic [17:0] d;
        logic [17:0] prev;
        t_a_ci = 0;
        t_wr_a(9'd5, 18'h00000, 2'b11);
        t_a_ci = 1;
        t_rd_b(9'd5, d);
        chk("R7", "write with input enable low ignored", 36'(d), 36'h2A5A5);
        t_b_ci = 0;
        t_rd_b(9'd12, d);
        t_b_ci = 1;
        chk("R7", "read with input enable low not accepted", 36'(d), 36'h2A5A5);
        prev = t_b_rd;
        t_b_co = 0;
        t_b_addr = 9'd12; t_b_re = 1;
        tick(1);
        t_b_re = 0;
        tick(3);
        chk("R8", "output holds with output enable low", 36'(t_b_rd), 36'(prev));
        t_b_co = 1;
        tick(1);
        chk("R8", "output loads after enable rises", 36'(t_b_rd), 36'h3FE01);
    endtask

    task automatic test_sdp();
        logic [35:0] v;
        v = 36'h912345678;
        s_a_addr = 8'd3; s_a_wd = 36'h0AAAAAAAA; s_a_we = 1;
        tick(1);
        s_a_addr = 8'd3; s_a_wd = v; s_a_we = 1; s_a_re = 1;
        s_b_addr = 8'd3; s_b_re = 1;
        tick(1);
        s_a_we = 0; s_a_re = 0; s_b_re = 0;
        chk("R5", "sdp read meets write, old word", s_b_rd, 36'h0AAAAAAAA);
        chk("R9", "sdp port A read data stays zero", s_a_rd, 36'h0);
        s_b_addr = 8'd3; s_b_wd = 36'h0; s_b_we = 1; s_b_re = 1;
        tick(1);
        s_b_we = 0; s_b_re = 0;
        chk("R2", "sdp one-cycle read", s_b_rd, v);
        s_b_re = 1;
        tick(1);
        s_b_re = 0;
        chk("R9", "port B write ignored", s_b_rd, v);
        s_a_addr = 8'd3; s_a_wd = 36'h0; s_a_be = 4'b0100; s_a_we = 1;
        tick(1);
        s_a_we = 0; s_a_be = 4'hF;
        s_b_addr = 8'd3; s_b_re = 1;
        tick(1);
        s_b_re = 0;
        chk("R4", "36-bit lane2 cleared", s_b_rd, v & ~(36'h1FF << 18));
        s_a_addr = 8'd255; s_a_wd = 36'hF0F0F0F0F; s_a_we = 1;
        tick(1);
        s_a_we = 0;
        s_b_addr = 8'd255; s_b_re = 1;
        tick(1);
        s_b_re = 0;
        chk("R1", "top address 255 of 256x36", s_b_rd, 36'hF0F0F0F0F);
    endtask

    task automatic test_split();
        p_a_addr = 10'd4; p_a_wd = 9'h1AA; p_a_we = 1;
        p_b_addr = 10'd4; p_b_wd = 9'h055; p_b_we = 1;
        tick(1);
        p_a_we = 0; p_b_we = 0;
        p_a_addr = 10'h204; p_a_re = 1;
        p_b_addr = 10'd4;   p_b_re = 1;
        tick(1);
        p_a_re = 0; p_b_re = 0;
        chk("R10", "port A half, MSB ignored", 36'(p_a_rd), 36'h1AA);
        chk("R10", "port B half separate", 36'(p_b_rd), 36'h055);
    endtask

    task automatic test_single();
        o_a_addr = 10'd2; o_a_wd = 8'h5C; o_a_we = 1;
        tick(1);
        o_a_we = 0;
        o_b_addr = 10'd2; o_b_wd = 8'hAB; o_b_we = 1; o_b_re = 1;
        tick(1);
        o_b_we = 0; o_b_re = 0;
        chk("R9", "single-port B read data zero", 36'(o_b_rd), 36'h0);
        o_a_addr = 10'd2; o_a_re = 1;
        tick(1);
        o_a_re = 0;
        chk("R9", "single-port B write ignored", 36'(o_a_rd), 36'h5C);
    endtask

    initial begin
        idle_all();
        rst = 1'b1;
        tick(3);
        rst = 1'b0;
        tick(1);
        test_reset();
        test_latency_depth();
        test_lanes_tdp();
        test_hold();
        test_collisions();
        test_enables();
        test_sdp();
        test_split();
        test_single();
        tick(2);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #400000;
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule